// File: doc/BRIEF.md
# UART Channel Register Interface

This block sits between a host register bus and the serial engine of one UART channel. The host sees three registers: a transmit data register, a receive data register and a status and flag register. The bus is synchronous. Address, write enable, read enable and write data are sampled on the rising clock edge. Read data is a combinational function of the address and the current state. Side effects of a read, such as popping the receive buffer or clearing flags, take effect at the edge on which the read enable is high.

On the transmit side, a write to the transmit register loads a one-byte buffer. That buffer is offered to the serial engine through a valid and accept handshake. On the receive side, each byte strobe from the engine pushes a byte into a two-entry FIFO. The strobe also carries frame-error and parity-error qualifiers. The flags clear in three different ways:
- some clear when software writes 1 to them;
- the receive-fill flags and the frame-error flag clear when the receive data is read;
- the transmit-empty flag follows the one-byte buffer.

An interrupt output combines the flags with an enable mask.

The register map is: address 0 holds transmit data (write-only, reads 0), address 1 holds receive data, address 2 holds status, and address 3 reads 0.

Top module: `uart_regif`

## Requirements
- R1: Data registers use bits 7..0. A read of address 0 or address 3 returns 0x0000, and a read of receive data returns the byte zero-extended, with bits 15..8 equal to 0.
- R2: After reset the status register reads 0x0001: only the transmit-empty flag (bit 0) is set.
- R3: The receive buffer holds at most two bytes. Each read of address 1 returns and removes the oldest byte. A read with the buffer empty returns 0x0000 and changes nothing.
- R4: Status bit 1 is 1 while the buffer holds at least one byte, and bit 2 is 1 while it holds two. Both follow the remaining count after every read.
- R5: A byte strobe that arrives while the buffer is full, with no receive read in the same cycle, discards the byte and sets the overrun flag (bit 3). Writing 1 to bit 3 clears the flag. A strobe in the same cycle as a read of a full buffer is accepted.
- R6: A strobe with the frame-error qualifier sets bit 5. Writing 1 to bit 5, or any read of address 1, clears it. A strobe with the parity-error qualifier sets bit 4, and only writing 1 to bit 4 clears it.
- R7: Writing 0 to any status bit has no effect, and writes to bits 2..0 and 9..7 have no effect. When a flag is set and cleared in the same cycle, the set wins.
- R8: A write to address 0 stores bits 7..0 in the buffer, raises tx_valid with that byte on tx_byte, and clears bit 0. A cycle with tx_valid and tx_accept high empties the buffer, so tx_valid falls and bit 0 returns to 1.
- R9: tx_done while the transmit buffer is empty sets the transmit-end flag (bit 6). tx_done while the buffer is full does not set it. Writing 1 to bit 6 clears it.
- R10: Status bit 9 shows rx_busy and bit 8 shows tx_busy in the same cycle, and neither bit is stored.
- R11: irq is 1 exactly when some status bit k in 6..0 is 1 and irq_enable[k] is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write enable |
| bus_rd | input | 1 | Read enable (pops receive data, clears read-cleared flags) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| tx_byte | output | 8 | Buffered transmit byte |
| tx_valid | output | 1 | Transmit buffer holds a byte |
| tx_accept | input | 1 | Engine takes the buffered byte |
| tx_busy | input | 1 | Engine is sending |
| tx_done | input | 1 | Engine finished a character |
| rx_byte | input | 8 | Received byte |
| rx_strobe | input | 1 | Received byte is valid this cycle |
| rx_ferr | input | 1 | Frame error qualifier for rx_byte |
| rx_perr | input | 1 | Parity error qualifier for rx_byte |
| rx_busy | input | 1 | Engine is receiving |
| irq_enable | input | 7 | Per-flag interrupt enable for status bits 6..0 |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions watch several rules on every cycle:
- the receive count never exceeds two;
- an overrun always leaves the overrun flag set and the buffer full;
- a transmit write always presents that byte as valid;
- an accept always empties the buffer;
- a receive read never clears the parity flag;
- tx_done with a full buffer never raises the transmit-end flag.

Only the bench scenarios can show four further behaviours: byte ordering through the buffer, which byte is dropped on overrun, set-over-clear priority when a strobe and a write-1 meet in one cycle, and the interrupt masking.

// File: rtl/uart_regif.sv
module uart_regif #(
  parameter int AW = 2,
  parameter int DW = 16,
  parameter int BW = 8,
  parameter int FD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [BW-1:0] tx_byte,
  output logic          tx_valid,
  input  logic          tx_accept,
  input  logic          tx_busy,
  input  logic          tx_done,
  input  logic [BW-1:0] rx_byte,
  input  logic          rx_strobe,
  input  logic          rx_ferr,
  input  logic          rx_perr,
  input  logic          rx_busy,
  input  logic [6:0]    irq_enable,
  output logic          irq
);
  localparam int CW = $clog2(FD + 1);
  localparam int PW = (FD > 1) ? $clog2(FD) : 1;
  localparam logic [AW-1:0] A_TXD  = AW'(0);
  localparam logic [AW-1:0] A_RXD  = AW'(1);
  localparam logic [AW-1:0] A_STAT = AW'(2);

  logic [BW-1:0] tx_buf;
  logic          tx_full;
  logic [BW-1:0] fifo [FD];
  logic [PW-1:0] rp, wp;
  logic [CW-1:0] cnt;
  logic          tend, fe, pe, oe;
  logic [9:0]    status;

  wire wr_txd  = bus_wr && bus_addr == A_TXD;
  wire wr_stat = bus_wr && bus_addr == A_STAT;
  wire rd_rxd  = bus_rd && bus_addr == A_RXD;
  wire empty   = cnt == '0;
  wire full    = cnt == CW'(FD);
  wire pop     = rd_rxd && !empty;
  wire push    = rx_strobe && (!full || pop);
  wire ovf     = rx_strobe && full && !pop;
  wire take    = tx_full && tx_accept;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(FD - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full <= 1'b0;
      tx_buf  <= '0;
    end else if (wr_txd) begin
      tx_full <= 1'b1;
      tx_buf  <= bus_wdata[BW-1:0];
    end else if (take) begin
      tx_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (push) fifo[wp] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else begin
      if (pop)  rp <= nxt(rp);
      if (push) wp <= nxt(wp);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tend <= 1'b0;
      fe   <= 1'b0;
      pe   <= 1'b0;
      oe   <= 1'b0;
    end else begin
      tend <= (tend && !(wr_stat && bus_wdata[6])) || (tx_done && !tx_full);
      fe   <= (fe && !(wr_stat && bus_wdata[5]) && !rd_rxd) || (rx_strobe && rx_ferr);
      pe   <= (pe && !(wr_stat && bus_wdata[4])) || (rx_strobe && rx_perr);
      oe   <= (oe && !(wr_stat && bus_wdata[3])) || ovf;
    end
  end

  assign status   = {rx_busy, tx_busy, 1'b0, tend, fe, pe, oe, full, !empty, !tx_full};
  assign irq      = |(status[6:0] & irq_enable);
  assign tx_valid = tx_full;
  assign tx_byte  = tx_buf;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_RXD && !empty) bus_rdata = DW'(fifo[rp]);
    else if (bus_addr == A_STAT)     bus_rdata = DW'(status);
  end

  assert_fifo_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(FD));

  assert_overrun_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> oe && full);

  assert_txd_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_txd |=> tx_valid && tx_byte == $past(bus_wdata[BW-1:0]));

  assert_accept_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_accept && !wr_txd) |=> !tx_valid);

  assert_parity_survives_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pe && rd_rxd && !(wr_stat && bus_wdata[4])) |=> pe);

  assert_tend_needs_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && tx_valid && !tend) |=> !tend);
endmodule

// File: tb/uart_regif_bench.sv
module uart_regif_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  tx_byte;
  logic        tx_valid;
  logic        tx_accept = 1'b0, tx_busy = 1'b0, tx_done = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_strobe = 1'b0, rx_ferr = 1'b0, rx_perr = 1'b0, rx_busy = 1'b0;
  logic [6:0]  irq_enable = '0;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  uart_regif u_uart_regif (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_byte(tx_byte), .tx_valid(tx_valid),
    .tx_accept(tx_accept), .tx_busy(tx_busy), .tx_done(tx_done), .rx_byte(rx_byte),
    .rx_strobe(rx_strobe), .rx_ferr(rx_ferr), .rx_perr(rx_perr), .rx_busy(rx_busy),
    .irq_enable(irq_enable), .irq(irq)
  );

  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (bus_rd) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        fails++;
        $display("FAIL %s: rdata actual=%h expected=%h", t, bus_rdata, e);
      end
    end
  end

  task automatic chk(string t, logic [15:0] act, logic [15:0] e);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", t, act, e);
    end
  endtask

  task automatic peek_irq(string t, logic e);
    @(negedge clk);
    #(CLK_P/4);
    chk(t, {15'd0, irq}, {15'd0, e});
  endtask

  task automatic rd(logic [1:0] a, logic [15:0] e, string t);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rx(logic [7:0] b, logic f, logic p);
    @(negedge clk);
    rx_byte = b; rx_ferr = f; rx_perr = p; rx_strobe = 1'b1;
    @(negedge clk);
    rx_strobe = 1'b0; rx_ferr = 1'b0; rx_perr = 1'b0;
  endtask

  task automatic pulse_accept();
    @(negedge clk); tx_accept = 1'b1;
    @(negedge clk); tx_accept = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(2'd2, 16'h0001, "R2 reset status");
    peek_irq("R2 irq at reset, mask 0", 1'b0);
    rd(2'd0, 16'h0000, "R1 txd reads zero");
    rd(2'd3, 16'h0000, "R1 unused address");

    rx(8'hA5, 0, 0);
    rd(2'd2, 16'h0003, "R4 one byte");
    rx(8'h3C, 0, 0);
    rd(2'd2, 16'h0007, "R4 two bytes");
    rd(2'd1, 16'h00A5, "R3 oldest first");
    rd(2'd2, 16'h0003, "R4 after read from full");
    rd(2'd1, 16'h003C, "R3 second byte");
    rd(2'd2, 16'h0001, "R4 drained");
    rd(2'd1, 16'h0000, "R3 empty read");
    rd(2'd2, 16'h0001, "R3 empty read no effect");

    rx(8'h11, 0, 0); rx(8'h22, 0, 0); rx(8'h33, 0, 0);
    rd(2'd2, 16'h000F, "R5 overrun flag");
    rd(2'd1, 16'h0011, "R5 first kept");
    rd(2'd1, 16'h0022, "R5 third dropped");
    rd(2'd2, 16'h0009, "R5 overrun persists");
    wr(2'd2, 16'h0000);
    rd(2'd2, 16'h0009, "R7 write zero no effect");
    wr(2'd2, 16'h0008);
    rd(2'd2, 16'h0001, "R5 overrun w1c");

    rx(8'h44, 1, 1);
    rd(2'd2, 16'h0033, "R6 fe and pe set");
    rd(2'd1, 16'h0044, "R6 byte");
    rd(2'd2, 16'h0011, "R6 read clears fe keeps pe");
    wr(2'd2, 16'h0010);
    rd(2'd2, 16'h0001, "R6 pe w1c");
    rx(8'h55, 1, 0);
    wr(2'd2, 16'h0020);
    rd(2'd2, 16'h0003, "R6 fe w1c");
    rd(2'd1, 16'h0055, "R6 drain");

    rx(8'h66, 0, 0);
    wr(2'd2, 16'h0387);
    rd(2'd2, 16'h0003, "R7 read-only bits unaffected");
    rd(2'd1, 16'h0066, "R7 drain");

    rx(8'h71, 1, 0);
    @(negedge clk);
    bus_addr = 2'd2; bus_wdata = 16'h0020; bus_wr = 1'b1;
    rx_byte = 8'h72; rx_ferr = 1'b1; rx_strobe = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; rx_strobe = 1'b0; rx_ferr = 1'b0;
    rd(2'd2, 16'h0027, "R7 set wins over clear");
    rd(2'd1, 16'h0071, "R7 drain a");
    rd(2'd1, 16'h0072, "R7 drain b");
    rd(2'd2, 16'h0001, "R6 fe cleared by read");

    rx(8'h81, 0, 0); rx(8'h82, 0, 0);
    @(negedge clk);
    bus_addr = 2'd1; bus_rd = 1'b1; exp_q.push_back(16'h0081); tag_q.push_back("R5 pop with push");
    rx_byte = 8'h83; rx_strobe = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; rx_strobe = 1'b0;
    rd(2'd2, 16'h0007, "R5 no overrun on pop+push");
    rd(2'd1, 16'h0082, "R3 order b");
    rd(2'd1, 16'h0083, "R3 order c");

    wr(2'd0, 16'h01C5);
    @(negedge clk); #(CLK_P/4);
    chk("R8 tx_valid after write", {15'd0, tx_valid}, 16'h0001);
    chk("R8 tx_byte low bits", {8'd0, tx_byte}, 16'h00C5);
    rd(2'd2, 16'h0000, "R8 tbe cleared");
    pulse_accept();
    @(negedge clk); #(CLK_P/4);
    chk("R8 tx_valid after accept", {15'd0, tx_valid}, 16'h0000);
    rd(2'd2, 16'h0001, "R8 tbe restored");

    pulse_done();
    rd(2'd2, 16'h0041, "R9 tend set");
    wr(2'd2, 16'h0040);
    rd(2'd2, 16'h0001, "R9 tend w1c");
    wr(2'd0, 16'h005A);
    pulse_done();
    rd(2'd2, 16'h0000, "R9 done with full buffer");
    pulse_accept();

    @(negedge clk); rx_busy = 1'b1;
    rd(2'd2, 16'h0201, "R10 rx busy");
    @(negedge clk); tx_busy = 1'b1;
    rd(2'd2, 16'h0301, "R10 both busy");
    @(negedge clk); rx_busy = 1'b0; tx_busy = 1'b0;
    rd(2'd2, 16'h0001, "R10 idle");

    @(negedge clk); irq_enable = 7'h01;
    peek_irq("R11 tbe enabled", 1'b1);
    @(negedge clk); irq_enable = 7'h7E;
    peek_irq("R11 tbe masked", 1'b0);
    rx(8'h90, 0, 0);
    peek_irq("R11 rb1 enabled", 1'b1);
    rd(2'd1, 16'h0090, "R11 drain");
    peek_irq("R11 rb1 cleared", 1'b0);

    repeat (2) @(negedge clk);
    chk("scoreboard empty", 16'(exp_q.size()), 16'h0000);
    done = 1'b1;
    summary();
  end
endmodule